// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers 32 system interrupt lines and presents one processor with a single interrupt level. Each line maps to a processor level through a fixed, mostly empty table. A pending register records source transitions, and a disable register masks them. A master-disable bit silences the whole controller. The highest level among the unmasked pending lines is latched as a request. Once a request is latched, nothing new is latched until the processor accepts it. The request is therefore held stable, and later or higher activity waits.

Software drives one write port with an operation code. The code clears bits from the disable register, sets bits in it (which also drops the matching pending bits), or selects the target CPU. Some bits are protected: a fixed mask forces them to zero in every enable or disable write. The processor-side acceptance check is also part of the block. A latched request is taken when the trap-enable flag is set and the level is either above the current priority level or equal to 15. Level 15 cannot be masked by priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `req_o`, `pend_o`, `dis_o` and `tgt_o` are all zero.
- R2: A 0-to-1 change on a source line sets its pending bit, and a 1-to-0 change clears it. A line that stays high does not set the bit again after the bit has been cleared by other means.
- R3: Source bit 28 maps to level 15, bit 25 to 11, bit 22 to 10, bit 23 to 8, bit 19 to 6 and bit 21 to 4. Every other bit maps to level 0.
- R4: The effective set is `pend_o & ~dis_o`. When it is nonzero and no request is latched, the maximum mapped level is latched at the next clock edge, and `req_o` rises with `req_level_o` equal to that level.
- R5: While `dis_o[31]` (master disable) is set, no new request is latched.
- R6: While a request is latched and not taken, `req_o` stays high and `req_level_o` holds, even if higher levels become pending.
- R7: A write with `wr_op_i`=0 (enable) clears the bits of `wr_data_i & ~32'h7FB2007F` from the disable register.
- R8: A write with `wr_op_i`=1 (disable) sets the bits of `wr_data_i & ~32'h7FB2007F` in the disable register and clears the same bits from pending.
- R9: A write with `wr_op_i`=2 stores `wr_data_i & (N_CPU-1)` into `tgt_o`.
- R10: `take_o` is high when a request is latched, `cpu_trap_en_i` is 1, and either the level is 15 or the level is greater than `cpu_pil_i`. After `take_o` is high, `req_o` is low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | 0 enable, 1 disable, 2 target CPU |
| wr_data_i | input | 32 | Write data |
| cpu_trap_en_i | input | 1 | Processor trap-enable flag |
| cpu_pil_i | input | 4 | Processor current priority level |
| req_o | output | 1 | A request is latched |
| req_level_o | output | 4 | Latched request level |
| take_o | output | 1 | Processor accepts the latched request this cycle |
| pend_o | output | 32 | Pending register |
| dis_o | output | 32 | Disable register |
| tgt_o | output | 2 | Selected target CPU |

## Verification
The assertions assume that the processor inputs are driven and stable around each clock edge. They also assume that a disable write and a source transition on the same bit never land in the same cycle, since the source change would then win. The stimulus changes inputs only between edges and always separates writes from source edges on the same bit. It also avoids latching a level-0 request, which no priority setting can accept. It drains all sources and accepts any outstanding request before each scenario begins.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned SRC_N = 32;
  localparam logic [SRC_N-1:0] WR_FORCE_MASK = 32'h7FB2007F;

  typedef enum logic [1:0] {
    OP_ENABLE  = 2'd0,
    OP_DISABLE = 2'd1,
    OP_TARGET  = 2'd2
  } wr_op_e;

  function automatic logic [3:0] lvl_of(int unsigned idx);
    case (idx)
      19:      lvl_of = 4'd6;
      21:      lvl_of = 4'd4;
      22:      lvl_of = 4'd10;
      23:      lvl_of = 4'd8;
      25:      lvl_of = 4'd11;
      28:      lvl_of = 4'd15;
      default: lvl_of = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned N_CPU = 4,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_op_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] dis_o,
  output logic [CPU_W-1:0] tgt_o
);
  logic [N_SRC-1:0] src_q, pend_q, dis_q, pend_n, dis_n, wmask, chg;
  logic [CPU_W-1:0] tgt_q;

  assign wmask = wr_data_i & ~WR_FORCE_MASK[N_SRC-1:0];
  assign chg   = src_i ^ src_q;

  always_comb begin
    pend_n = pend_q;
    dis_n  = dis_q;
    if (wr_en_i) begin
      case (wr_op_e'(wr_op_i))
        OP_ENABLE:  dis_n = dis_q & ~wmask;
        OP_DISABLE: begin
          dis_n  = dis_q | wmask;
          pend_n = pend_q & ~wmask;
        end
        default: ;
      endcase
    end
    // source transitions take precedence over a same-cycle write
    pend_n = (pend_n & ~chg) | (src_i & chg);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
      dis_q  <= '0;
      tgt_q  <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_n;
      dis_q  <= dis_n;
      if (wr_en_i && wr_op_e'(wr_op_i) == OP_TARGET)
        tgt_q <= wr_data_i[CPU_W-1:0] & CPU_W'(N_CPU - 1);
    end
  end

  assign pend_o = pend_q;
  assign dis_o  = dis_q;
  assign tgt_o  = tgt_q;
endmodule

// File: rtl/irq_lvl_search.sv
module irq_lvl_search
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned LVL_W = 4
) (
  input  logic [N_SRC-1:0] eff_i,
  output logic             any_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] lv [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_map
    assign lv[g] = eff_i[g] ? LVL_W'(lvl_of(g)) : '0;
  end

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (lv[i] > lvl_o) lvl_o = lv[i];
  end

  assign any_o = |eff_i;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic             master_dis_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             trap_en_i,
  input  logic [LVL_W-1:0] pil_i,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             take_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic             req_q;
  logic [LVL_W-1:0] lvl_q;

  assign take_o = req_q && trap_en_i && (lvl_q == LVL_TOP || lvl_q > pil_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      lvl_q <= '0;
    end else if (take_o) begin
      req_q <= 1'b0;
    end else if (!req_q && any_i && !master_dis_i) begin
      req_q <= 1'b1;
      lvl_q <= lvl_i;
    end
  end

  assign req_o = req_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned N_CPU = 4,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_op_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic             cpu_trap_en_i,
  input  logic [LVL_W-1:0] cpu_pil_i,
  output logic             req_o,
  output logic [LVL_W-1:0] req_level_o,
  output logic             take_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] dis_o,
  output logic [CPU_W-1:0] tgt_o
);
  logic [N_SRC-1:0] eff;
  logic             any;
  logic [LVL_W-1:0] max_lvl;

  irq_src_regs #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_regs (
    .clk_i, .rst_ni, .src_i, .wr_en_i, .wr_op_i, .wr_data_i,
    .pend_o, .dis_o, .tgt_o
  );

  assign eff = pend_o & ~dis_o;

  irq_lvl_search #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_search (
    .eff_i(eff), .any_o(any), .lvl_o(max_lvl)
  );

  irq_req_latch #(.LVL_W(LVL_W)) u_latch (
    .clk_i, .rst_ni,
    .any_i(any), .master_dis_i(dis_o[N_SRC-1]), .lvl_i(max_lvl),
    .trap_en_i(cpu_trap_en_i), .pil_i(cpu_pil_i),
    .req_o, .lvl_o(req_level_o), .take_o
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned LVL_W = 4,
  parameter int unsigned CPU_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_op_i,
  input logic [N_SRC-1:0] wr_data_i,
  input logic             cpu_trap_en_i,
  input logic             req_o,
  input logic [LVL_W-1:0] req_level_o,
  input logic             take_o,
  input logic [N_SRC-1:0] pend_o,
  input logic [N_SRC-1:0] dis_o
);
  localparam logic [N_SRC-1:0] KEEP = ~WR_FORCE_MASK[N_SRC-1:0];

  a_r10_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !req_o);

  a_r10_no_trap_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_trap_en_i |-> !take_o);

  a_r10_top_level_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && cpu_trap_en_i && req_level_o == {LVL_W{1'b1}}) |-> take_o);

  a_r6_hold_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !take_o) |=> (req_o && $stable(req_level_o)));

  a_r5_master_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && dis_o[N_SRC-1]) |=> !req_o);

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && (pend_o & ~dis_o) == '0) |=> !req_o);

  a_r8_disable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_op_i == 2'd1) |=>
      ((dis_o & $past(wr_data_i & KEEP)) == $past(wr_data_i & KEEP)));

  a_r7_enable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_op_i == 2'd0) |=> ((dis_o & $past(wr_data_i & KEEP)) == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W), .CPU_W(CPU_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_op_i, .wr_data_i, .cpu_trap_en_i,
  .req_o, .req_level_o, .take_o, .pend_o, .dis_o
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_op_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        cpu_trap_en_i = 1'b0;
  logic [3:0]  cpu_pil_i = '0;
  logic        req_o, take_o;
  logic [3:0]  req_level_o;
  logic [31:0] pend_o, dis_o;
  logic [1:0]  tgt_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic [1:0] op, logic [31:0] d);
    wr_en_i = 1'b1; wr_op_i = op; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic drain();
    src_i = '0; cpu_trap_en_i = 1'b1; cpu_pil_i = '0;
    step(3);
    cpu_trap_en_i = 1'b0;
    step(1);
    chk("R2 drained", {31'd0, req_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 req", {31'd0, req_o}, 32'd0);
    chk("R1 pend", pend_o, 32'd0);
    chk("R1 dis", dis_o, 32'd0);
    chk("R1 tgt", {30'd0, tgt_o}, 32'd0);
  endtask

  task automatic t_single();
    src_i[19] = 1'b1;
    step(1);
    chk("R2 pend set", pend_o, 32'h0008_0000);
    chk("R4 not yet", {31'd0, req_o}, 32'd0);
    step(1);
    chk("R4 req", {31'd0, req_o}, 32'd1);
    chk("R3 lvl 6", {28'd0, req_level_o}, 32'd6);
    drain();
  endtask

  task automatic t_max_and_pil();
    src_i[19] = 1'b1; src_i[22] = 1'b1; src_i[23] = 1'b1;
    step(2);
    chk("R3 max lvl 10", {28'd0, req_level_o}, 32'd10);
    cpu_trap_en_i = 1'b1; cpu_pil_i = 4'd10; #1;
    chk("R10 equal pil no take", {31'd0, take_o}, 32'd0);
    cpu_pil_i = 4'd9; #1;
    chk("R10 take", {31'd0, take_o}, 32'd1);
    step(1);
    cpu_trap_en_i = 1'b0;
    chk("R10 cleared", {31'd0, req_o}, 32'd0);
    step(1);
    chk("R4 relatch", {28'd0, req_level_o} | {31'd0, req_o} << 4, 32'h1A);
    drain();
  endtask

  task automatic t_defer_and_nmi();
    src_i[19] = 1'b1;
    step(2);
    src_i[28] = 1'b1;
    step(2);
    chk("R6 held req", {31'd0, req_o}, 32'd1);
    chk("R6 held lvl", {28'd0, req_level_o}, 32'd6);
    cpu_trap_en_i = 1'b1; cpu_pil_i = 4'd0;
    step(1);
    cpu_trap_en_i = 1'b0;
    chk("R10 cleared", {31'd0, req_o}, 32'd0);
    step(1);
    chk("R3 lvl 15", {28'd0, req_level_o}, 32'd15);
    cpu_pil_i = 4'd15; #1;
    chk("R10 trap off", {31'd0, take_o}, 32'd0);
    cpu_trap_en_i = 1'b1; #1;
    chk("R10 lvl15 unmaskable", {31'd0, take_o}, 32'd1);
    step(1);
    cpu_trap_en_i = 1'b0;
    drain();
  endtask

  task automatic t_disable_enable();
    wr(2'd1, 32'h0008_0000);
    chk("R8 dis set", dis_o, 32'h0008_0000);
    src_i[19] = 1'b1;
    step(3);
    chk("R4 masked pend", pend_o, 32'h0008_0000);
    chk("R4 masked no req", {31'd0, req_o}, 32'd0);
    wr(2'd1, 32'h0008_0000);
    chk("R8 pend cleared", pend_o, 32'd0);
    wr(2'd0, 32'h0008_0000);
    chk("R7 dis cleared", dis_o, 32'd0);
    step(1);
    chk("R2 steady no reset", pend_o, 32'd0);
    chk("R2 steady no req", {31'd0, req_o}, 32'd0);
    src_i[19] = 1'b0; step(1);
    src_i[19] = 1'b1; step(2);
    chk("R2 re-edge req", {28'd0, req_level_o} | {31'd0, req_o} << 4, 32'h16);
    drain();
  endtask

  task automatic t_master();
    wr(2'd1, 32'h8000_0000);
    src_i[22] = 1'b1;
    step(3);
    chk("R5 blocked", {31'd0, req_o}, 32'd0);
    wr(2'd0, 32'h8000_0000);
    chk("R5 still none", {31'd0, req_o}, 32'd0);
    step(1);
    chk("R5 released", {28'd0, req_level_o} | {31'd0, req_o} << 4, 32'h1A);
    drain();
  endtask

  task automatic t_force_mask();
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R8 forced mask", dis_o, 32'h804D_FF80);
    src_i[28] = 1'b1;
    step(2);
    chk("R5 all disabled", {31'd0, req_o}, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R7 all enabled", dis_o, 32'd0);
    step(1);
    chk("R7 lvl15 req", {28'd0, req_level_o} | {31'd0, req_o} << 4, 32'h1F);
    wr(2'd1, 32'h1000_0000);
    chk("R8 bit28 ignored", dis_o, 32'd0);
    drain();
  endtask

  task automatic t_target();
    wr(2'd2, 32'h0000_0007);
    chk("R9 tgt masked", {30'd0, tgt_o}, 32'd3);
    wr(2'd2, 32'h0000_0006);
    chk("R9 tgt 2", {30'd0, tgt_o}, 32'd2);
  endtask

  initial begin
    #1;
    chk("R1 req in reset", {31'd0, req_o}, 32'd0);
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_max_and_pil();
    t_defer_and_nmi();
    t_disable_enable();
    t_master();
    t_force_mask();
    t_target();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule